// File: doc/BRIEF.md
# Last Branch Record Unit

This block keeps a small trace of control flow for debug software. While the record-enable bit of its debug-control register is set, each qualifying control-transfer event overwrites a branch pair with the event's source and target offsets. When the event is an interrupt or an exception, the branch pair's previous contents move into a second pair first. That second pair therefore holds the last transfer taken before the interrupt or exception. Debug exceptions raised by a breakpoint or by the one-byte debug trap are exempt from that move.

For guest/host operation the block swaps all five registers with an external save area in one step. The five registers are the debug control and the four records. The swap happens on a world-entry or world-exit strobe, and only while register virtualization is enabled. In the swap cycle the block raises a store strobe. The current register outputs act as the save-out data in that same cycle, and the save-in values load at the clock edge.

Top module: `lbr_unit`

## Requirements
- R1: After reset, the debug control and all four record registers read zero and `sv_we` is low.
- R2: A `ctl_we` pulse loads `ctl_wdata` into `dbg_ctl` at the next edge, unless a swap occurs in the same cycle.
- R3: An event arriving while `dbg_ctl` bit `EN_BIT` (default bit 0) is 0 changes no record register. A cycle with no event, no control write and no swap changes no register.
- R4: An enabled event with `ev_kind` = 0 (branch) loads `br_from`/`br_to` with `ev_from`/`ev_to` at the next edge. It leaves `ex_from`/`ex_to` unchanged.
- R5: An enabled event with `ev_kind` = 1 (interrupt) or 2 (exception) copies the old `br_from`/`br_to` into `ex_from`/`ex_to` and loads the branch pair with the new offsets, all at the same edge.
- R6: An enabled event with `ev_kind` = 3 (breakpoint or debug-trap exception) loads the branch pair but leaves `ex_from`/`ex_to` unchanged.
- R7: When `virt_en` is 1 and `enter` or `leave` is high, `sv_we` is high in that same cycle. The outputs then still show the old five values, and all five registers take the `sv_in_*` values at the next edge.
- R8: When `virt_en` is 0, `enter` and `leave` have no effect. `sv_we` stays low and the registers do not take the `sv_in_*` values.
- R9: If a swap and an event or a control write fall in the same cycle, the swap alone takes effect. The event and the write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Control-transfer event strobe |
| ev_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 breakpoint/debug-trap exception |
| ev_from | input | AW | Source offset of the transfer |
| ev_to | input | AW | Target offset of the transfer |
| ctl_we | input | 1 | Debug-control write strobe |
| ctl_wdata | input | CW | Debug-control write value |
| virt_en | input | 1 | Register virtualization enable |
| enter | input | 1 | World-entry strobe |
| leave | input | 1 | World-exit strobe |
| sv_in_ctl | input | CW | Save-area debug control to load |
| sv_in_bfrom | input | AW | Save-area branch-from to load |
| sv_in_bto | input | AW | Save-area branch-to to load |
| sv_in_xfrom | input | AW | Save-area exception-from to load |
| sv_in_xto | input | AW | Save-area exception-to to load |
| sv_we | output | 1 | Swap strobe; the five outputs below are the save-out data in this cycle |
| dbg_ctl | output | CW | Debug-control register |
| br_from | output | AW | Branch-from record |
| br_to | output | AW | Branch-to record |
| ex_from | output | AW | Exception-from record |
| ex_to | output | AW | Exception-to record |

## Verification
`sv_we` is combinational, so the bench checks it shortly after driving the inputs, before the next clock edge. In that same window it checks that the outputs still hold the pre-swap values. Every register result lands exactly one edge after its stimulus. The bench therefore applies its model update once per edge and compares all five outputs just after that edge, before new inputs are driven. Random cycles mix events, control writes and swap strobes so that coincident cycles occur often. Directed cycles then pin down disabled recording, the dropped event under a swap, and strobes with virtualization off.

// File: rtl/lbr_unit.sv
module lbr_unit #(
  parameter int AW     = 64,
  parameter int CW     = 64,
  parameter int EN_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [AW-1:0] ev_from,
  input  logic [AW-1:0] ev_to,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          virt_en,
  input  logic          enter,
  input  logic          leave,
  input  logic [CW-1:0] sv_in_ctl,
  input  logic [AW-1:0] sv_in_bfrom,
  input  logic [AW-1:0] sv_in_bto,
  input  logic [AW-1:0] sv_in_xfrom,
  input  logic [AW-1:0] sv_in_xto,
  output logic          sv_we,
  output logic [CW-1:0] dbg_ctl,
  output logic [AW-1:0] br_from,
  output logic [AW-1:0] br_to,
  output logic [AW-1:0] ex_from,
  output logic [AW-1:0] ex_to
);

  localparam logic [1:0] K_INT = 2'd1;
  localparam logic [1:0] K_EXC = 2'd2;

  logic swap_go, rec_go, push_go;

  assign swap_go = virt_en & (enter | leave);
  assign rec_go  = ev_valid & dbg_ctl[EN_BIT] & ~swap_go;
  assign push_go = rec_go & ((ev_kind == K_INT) | (ev_kind == K_EXC));
  assign sv_we   = swap_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_ctl <= '0;
      br_from <= '0;
      br_to   <= '0;
      ex_from <= '0;
      ex_to   <= '0;
    end else if (swap_go) begin
      dbg_ctl <= sv_in_ctl;
      br_from <= sv_in_bfrom;
      br_to   <= sv_in_bto;
      ex_from <= sv_in_xfrom;
      ex_to   <= sv_in_xto;
    end else begin
      if (ctl_we) dbg_ctl <= ctl_wdata;
      if (rec_go) begin
        br_from <= ev_from;
        br_to   <= ev_to;
      end
      if (push_go) begin
        ex_from <= br_from;
        ex_to   <= br_to;
      end
    end
  end

endmodule

// File: rtl/lbr_unit_chk.sv
module lbr_unit_chk #(
  parameter int AW     = 64,
  parameter int CW     = 64,
  parameter int EN_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic [1:0]    ev_kind,
  input logic [AW-1:0] ev_from,
  input logic [AW-1:0] ev_to,
  input logic          ctl_we,
  input logic          virt_en,
  input logic [CW-1:0] sv_in_ctl,
  input logic [AW-1:0] sv_in_bfrom,
  input logic [AW-1:0] sv_in_bto,
  input logic [AW-1:0] sv_in_xfrom,
  input logic [AW-1:0] sv_in_xto,
  input logic          sv_we,
  input logic [CW-1:0] dbg_ctl,
  input logic [AW-1:0] br_from,
  input logic [AW-1:0] br_to,
  input logic [AW-1:0] ex_from,
  input logic [AW-1:0] ex_to
);

  logic en_rec;
  assign en_rec = ev_valid & dbg_ctl[EN_BIT] & ~sv_we;

  // R7
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_we |=> (dbg_ctl == $past(sv_in_ctl)) && (br_from == $past(sv_in_bfrom)) &&
              (br_to == $past(sv_in_bto)) && (ex_from == $past(sv_in_xfrom)) &&
              (ex_to == $past(sv_in_xto)));

  // R8
  virt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_en |-> !sv_we);

  // R4
  branch_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rec && ev_kind == 2'd0) |=> (br_from == $past(ev_from)) && (br_to == $past(ev_to)) &&
                                    $stable(ex_from) && $stable(ex_to));

  // R5
  push_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rec && (ev_kind == 2'd1 || ev_kind == 2'd2)) |=>
      (ex_from == $past(br_from)) && (ex_to == $past(br_to)) &&
      (br_from == $past(ev_from)) && (br_to == $past(ev_to)));

  // R6
  dbg_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rec && ev_kind == 2'd3) |=> $stable(ex_from) && $stable(ex_to) &&
                                    (br_from == $past(ev_from)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_we && !ctl_we && !en_rec) |=> $stable(dbg_ctl) && $stable(br_from) &&
                                       $stable(br_to) && $stable(ex_from) && $stable(ex_to));

endmodule

bind lbr_unit lbr_unit_chk #(.AW(AW), .CW(CW), .EN_BIT(EN_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .ev_from(ev_from), .ev_to(ev_to), .ctl_we(ctl_we), .virt_en(virt_en),
  .sv_in_ctl(sv_in_ctl), .sv_in_bfrom(sv_in_bfrom), .sv_in_bto(sv_in_bto),
  .sv_in_xfrom(sv_in_xfrom), .sv_in_xto(sv_in_xto), .sv_we(sv_we),
  .dbg_ctl(dbg_ctl), .br_from(br_from), .br_to(br_to), .ex_from(ex_from), .ex_to(ex_to)
);

// File: tb/lbr_unit_tb_top.sv
module lbr_unit_tb_top;
  localparam int AW = 64;
  localparam int CW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ctl_we = 1'b0, virt_en = 1'b0, enter = 1'b0, leave = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [AW-1:0] ev_from = '0, ev_to = '0;
  logic [CW-1:0] ctl_wdata = '0, sv_in_ctl = '0;
  logic [AW-1:0] sv_in_bfrom = '0, sv_in_bto = '0, sv_in_xfrom = '0, sv_in_xto = '0;
  logic sv_we;
  logic [CW-1:0] dbg_ctl;
  logic [AW-1:0] br_from, br_to, ex_from, ex_to;

  int n_chk = 0, n_bad = 0;
  logic [CW-1:0] m_ctl;
  logic [AW-1:0] m_bf, m_bt, m_xf, m_xt;

  always #2 clk = ~clk;

  lbr_unit #(.AW(AW), .CW(CW), .EN_BIT(0)) dut_i (.*);

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic swap_now();
    return virt_en & (enter | leave);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "dbg_ctl", dbg_ctl, m_ctl);
    chk(tag, "br_from", br_from, m_bf);
    chk(tag, "br_to",   br_to,   m_bt);
    chk(tag, "ex_from", ex_from, m_xf);
    chk(tag, "ex_to",   ex_to,   m_xt);
  endtask

  function automatic string tag_of();
    if (swap_now()) return (ev_valid | ctl_we) ? "R9" : "R7";
    if ((enter | leave) & !virt_en) return "R8";
    if (ev_valid & !m_ctl[0]) return "R3";
    if (ev_valid) return (ev_kind == 2'd0) ? "R4" : (ev_kind == 2'd3) ? "R6" : "R5";
    if (ctl_we) return "R2";
    return "R3";
  endfunction

  task automatic model_step();
    logic [AW-1:0] obf, obt;
    obf = m_bf; obt = m_bt;
    if (swap_now()) begin
      m_ctl = sv_in_ctl; m_bf = sv_in_bfrom; m_bt = sv_in_bto;
      m_xf = sv_in_xfrom; m_xt = sv_in_xto;
    end else begin
      if (ev_valid && m_ctl[0]) begin
        m_bf = ev_from; m_bt = ev_to;
        if (ev_kind == 2'd1 || ev_kind == 2'd2) begin m_xf = obf; m_xt = obt; end
      end
      if (ctl_we) m_ctl = ctl_wdata;
    end
  endtask

  task automatic cycle();
    string t;
    t = tag_of();
    #1;
    chk(t, "sv_we", sv_we, swap_now());
    if (swap_now()) chk_all("R7");
    @(posedge clk);
    model_step();
    #1;
    chk_all(t);
    @(negedge clk);
    {ev_valid, ctl_we, enter, leave} = '0;
  endtask

  task automatic rand_stim();
    ev_valid = ($urandom_range(99) < 60);
    ev_kind = 2'($urandom_range(3));
    ev_from = rnd64(); ev_to = rnd64();
    ctl_we = ($urandom_range(99) < 10);
    ctl_wdata = {rnd64()[63:1], ($urandom_range(3) != 0)};
    virt_en = ($urandom_range(99) < 70);
    enter = ($urandom_range(99) < 6);
    leave = ($urandom_range(99) < 6);
    sv_in_ctl = {rnd64()[63:1], ($urandom_range(3) != 0)};
    sv_in_bfrom = rnd64(); sv_in_bto = rnd64();
    sv_in_xfrom = rnd64(); sv_in_xto = rnd64();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ctl = '0; m_bf = '0; m_bt = '0; m_xf = '0; m_xt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_all("R1");
    chk("R1", "sv_we", sv_we, 1'b0);
    @(negedge clk);
    // R3: disabled recording
    ev_valid = 1; ev_kind = 2'd1; ev_from = 64'h11; ev_to = 64'h22; cycle();
    // R2: enable recording
    ctl_we = 1; ctl_wdata = 64'h1; cycle();
    // R4 then R5 then R6
    ev_valid = 1; ev_kind = 2'd0; ev_from = 64'hA0; ev_to = 64'hB0; cycle();
    ev_valid = 1; ev_kind = 2'd2; ev_from = 64'hA1; ev_to = 64'hB1; cycle();
    ev_valid = 1; ev_kind = 2'd3; ev_from = 64'hA2; ev_to = 64'hB2; cycle();
    // R8: strobe with virtualization off
    virt_en = 0; enter = 1; sv_in_bfrom = 64'hDEAD; cycle();
    // R9: swap beats event and control write
    virt_en = 1; enter = 1; ev_valid = 1; ev_kind = 2'd1; ev_from = 64'hEE; ev_to = 64'hFF;
    ctl_we = 1; ctl_wdata = 64'h0;
    sv_in_ctl = 64'h1; sv_in_bfrom = 64'h100; sv_in_bto = 64'h200;
    sv_in_xfrom = 64'h300; sv_in_xto = 64'h400; cycle();
    leave = 1; sv_in_ctl = 64'h5; cycle();
    for (int i = 0; i < 3000; i++) begin
      rand_stim();
      cycle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule